// File: doc/BRIEF.md
# Double-Precision Range Select Unit

This block compares two binary64 floating-point operands and returns one of them, chosen by a 4-bit mode field. The selection can be the minimum, the maximum, the operand of smaller magnitude or the operand of larger magnitude. An independent sign mode then either keeps the sign of the chosen value or replaces it: with the first operand's sign, with 0, or with 1. A common use is clamping a value to ±limit. Select min-by-magnitude against the limit and take the first operand's sign.

The unit has fixed outcomes for the cases that an ordinary min/max leaves open. These are signalling and quiet NaNs, zeros of opposite sign, and nonzero operands of equal magnitude and opposite sign. It reports an invalid flag and a denormal flag, and it has an optional denormals-are-zero mode. Any nonzero bit in the upper control nibble raises a separate illegal-control output. The datapath is combinational. By default it is followed by one output register that loads on `in_valid`.

Top module: `dp_range_sel`

## Requirements
- R1: With mode bits ctl[1:0]=00 the first operand is chosen when first ≤ second and the second otherwise. With 01 the second is chosen when first ≤ second and the first otherwise.
- R2: With ctl[1:0]=10 the first operand is chosen when |first| ≤ |second| and the second otherwise. With 11 the second is chosen when |first| ≤ |second| and the first otherwise.
- R3: Result bits [62:0] come from the chosen value. Bit 63 depends on ctl[3:2]: 00 gives the first operand's sign, 01 keeps the chosen value's sign, 10 gives 0, and 11 gives 1.
- R4: A signalling NaN has exponent all ones, bit 51 clear and a nonzero fraction. If the first operand is one, the result is the first operand with bit 51 set. Otherwise, if the second operand is one, the result is the second operand with bit 51 set. In both cases invalid is raised, the sign mode is not applied and the denormal flag stays low.
- R5: A quiet NaN has exponent all ones and bit 51 set. If the second operand is a quiet NaN the first operand is chosen. Otherwise, if the first operand is a quiet NaN, the second is chosen. Invalid stays low and the sign mode still applies.
- R6: For zeros of opposite sign, modes 00 and 10 choose -0 and modes 01 and 11 choose +0, in either operand order.
- R7: For nonzero, non-NaN operands of equal magnitude and opposite sign, mode 10 chooses the negative operand and mode 11 the positive one, in either order.
- R8: An operand with a zero exponent and a nonzero fraction is denormal. With denormals-are-zero off, a denormal operand raises the denormal flag unless the other operand is a quiet NaN.
- R9: With denormals-are-zero on, a denormal operand is replaced by a zero of the same sign for comparison and selection, and the denormal flag stays low.
- R10: ctl_illegal is high whenever ctl[7:4] is nonzero. The result is then formed from ctl[3:0] as usual.
- R11: In reset, out_valid, result and all flags are 0. A request with in_valid high appears on the outputs one clock later with out_valid high. While in_valid is low, out_valid is low and result and flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; loads the output register |
| opnd_a | input | 64 | First operand, binary64 |
| opnd_b | input | 64 | Second operand, binary64 |
| ctl | input | 8 | [1:0] selection mode, [3:2] sign mode, [7:4] must be zero |
| daz_en | input | 1 | Treat denormal operands as signed zero |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Selected value after sign handling |
| flag_invalid | output | 1 | A signalling NaN was seen |
| flag_denorm | output | 1 | A denormal operand was compared |
| ctl_illegal | output | 1 | Reserved control bits were nonzero |

## Verification
Uniformly random 64-bit operands almost never produce NaNs, signed zeros, denormals or pairs of equal magnitude. The paths that most need checking are therefore the hardest to reach from the ports. The stimulus draws each operand from a weighted set of classes: random pattern, signed zero, infinity, quiet NaN, signalling NaN, denormal, the other operand negated, and the other operand's magnitude with a random sign. This hits the opposite-zero and equal-magnitude tie-breaks, and the NaN priority order in both operand positions, many times. Directed vectors add the clamp use case and denormals flushed with DAZ to a signed zero.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   typedef enum logic [1:0] {
      CMP_MIN    = 2'b00,
      CMP_MAX    = 2'b01,
      CMP_MINMAG = 2'b10,
      CMP_MAXMAG = 2'b11
   } cmp_op_e;

   typedef enum logic [1:0] {
      SGN_FIRST = 2'b00,
      SGN_KEEP  = 2'b01,
      SGN_CLEAR = 2'b10,
      SGN_SET   = 2'b11
   } sgn_mode_e;

   typedef struct packed {
      logic snan;
      logic qnan;
      logic zero;
      logic denorm;
   } opnd_cls_t;
endpackage

// File: rtl/dpr_classify.sv
module dpr_classify
   import dpr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int W      = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] opnd,
   input  logic         daz_en,
   output opnd_cls_t    cls,
   output logic [W-1:0] flushed
);
   logic [EXP_W-1:0]  expo;
   logic [FRAC_W-1:0] frac;
   logic              exp_max, exp_zero, frac_nz;

   assign expo     = opnd[W-2:FRAC_W];
   assign frac     = opnd[FRAC_W-1:0];
   assign exp_max  = &expo;
   assign exp_zero = ~|expo;
   assign frac_nz  = |frac;

   always_comb begin
      cls.snan   = exp_max & frac_nz & ~frac[FRAC_W-1];
      cls.qnan   = exp_max & frac[FRAC_W-1];
      cls.denorm = exp_zero & frac_nz;
      // a flushed denormal counts as zero from here on
      cls.zero   = exp_zero & (~frac_nz | daz_en);
      flushed    = (daz_en & cls.denorm) ? {opnd[W-1], {(W-1){1'b0}}} : opnd;
   end
endmodule

// File: rtl/dpr_select.sv
module dpr_select
   import dpr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int W      = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] fa,
   input  logic [W-1:0] fb,
   input  logic         qnan_a,
   input  logic         qnan_b,
   input  logic         zero_a,
   input  logic         zero_b,
   input  cmp_op_e      op,
   output logic [W-1:0] sel_val
);
   logic [W-2:0] mag_a, mag_b;
   logic         sa, sb, opp, mag_le, mag_ge, mag_eq, val_le;

   assign mag_a  = fa[W-2:0];
   assign mag_b  = fb[W-2:0];
   assign sa     = fa[W-1];
   assign sb     = fb[W-1];
   assign opp    = sa ^ sb;
   assign mag_le = (mag_a <= mag_b);
   assign mag_ge = (mag_b <= mag_a);
   assign mag_eq = mag_le & mag_ge;

   // signed order on sign-magnitude values (opposite zeros handled below)
   always_comb begin
      if (opp)      val_le = sa;
      else if (!sa) val_le = mag_le;
      else          val_le = mag_ge;
   end

   always_comb begin
      if (qnan_b)
         sel_val = fa;
      else if (qnan_a)
         sel_val = fb;
      else if (opp && zero_a && zero_b)
         sel_val = {~op[0], {(W-1){1'b0}}};
      else if (opp && mag_eq && op[1])
         // min-magnitude keeps the negative one, max-magnitude the positive
         sel_val = (op[0] ^ sa) ? fa : fb;
      else begin
         unique case (op)
            CMP_MIN:    sel_val = val_le ? fa : fb;
            CMP_MAX:    sel_val = val_le ? fb : fa;
            CMP_MINMAG: sel_val = mag_le ? fa : fb;
            default:    sel_val = mag_le ? fb : fa;
         endcase
      end
   end
endmodule

// File: rtl/dpr_finish.sv
module dpr_finish
   import dpr_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int W      = 1 + EXP_W + FRAC_W
) (
   input  logic [W-1:0] raw_a,
   input  logic [W-1:0] raw_b,
   input  logic         snan_a,
   input  logic         snan_b,
   input  logic         qnan_a,
   input  logic         qnan_b,
   input  logic         dn_a,
   input  logic         dn_b,
   input  logic         daz_en,
   input  logic [W-1:0] sel_val,
   input  sgn_mode_e    smode,
   output logic [W-1:0] res,
   output logic         inv,
   output logic         den
);
   localparam logic [W-1:0] QUIET_BIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic sign_out;

   always_comb begin
      unique case (smode)
         SGN_FIRST: sign_out = raw_a[W-1];
         SGN_KEEP:  sign_out = sel_val[W-1];
         SGN_CLEAR: sign_out = 1'b0;
         default:   sign_out = 1'b1;
      endcase
   end

   always_comb begin
      inv = snan_a | snan_b;
      if (snan_a)      res = raw_a | QUIET_BIT;
      else if (snan_b) res = raw_b | QUIET_BIT;
      else             res = {sign_out, sel_val[W-2:0]};
      den = ~daz_en & ~inv & ((dn_a & ~qnan_b) | (dn_b & ~qnan_a));
   end
endmodule

// File: rtl/dp_range_sel.sv
module dp_range_sel
   import dpr_pkg::*;
#(
   parameter int EXP_W   = 11,
   parameter int FRAC_W  = 52,
   parameter int CTL_W   = 8,
   parameter int REG_OUT = 1,
   parameter int W       = 1 + EXP_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [W-1:0]     opnd_a,
   input  logic [W-1:0]     opnd_b,
   input  logic [CTL_W-1:0] ctl,
   input  logic             daz_en,
   output logic             out_valid,
   output logic [W-1:0]     result,
   output logic             flag_invalid,
   output logic             flag_denorm,
   output logic             ctl_illegal
);
   localparam int NOPS = 2;

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_fmt
      $error("dp_range_sel: exponent and fraction need at least 2 bits");
   end
   if (CTL_W < 5) begin : g_bad_ctl
      $error("dp_range_sel: control needs reserved bits above bit 3");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("dp_range_sel: REG_OUT must be 0 or 1");
   end

   logic [W-1:0] ops     [NOPS];
   logic [W-1:0] flat    [NOPS];
   opnd_cls_t    cls     [NOPS];
   logic [W-1:0] sel_val, c_res;
   logic         c_inv, c_den, c_ill;

   assign ops[0] = opnd_a;
   assign ops[1] = opnd_b;

   for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
      dpr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .W(W)) u_cls (
         .opnd    (ops[gi]),
         .daz_en  (daz_en),
         .cls     (cls[gi]),
         .flushed (flat[gi])
      );
   end

   dpr_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .W(W)) u_sel (
      .fa      (flat[0]),
      .fb      (flat[1]),
      .qnan_a  (cls[0].qnan),
      .qnan_b  (cls[1].qnan),
      .zero_a  (cls[0].zero),
      .zero_b  (cls[1].zero),
      .op      (cmp_op_e'(ctl[1:0])),
      .sel_val (sel_val)
   );

   dpr_finish #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .W(W)) u_fin (
      .raw_a   (opnd_a),
      .raw_b   (opnd_b),
      .snan_a  (cls[0].snan),
      .snan_b  (cls[1].snan),
      .qnan_a  (cls[0].qnan),
      .qnan_b  (cls[1].qnan),
      .dn_a    (cls[0].denorm),
      .dn_b    (cls[1].denorm),
      .daz_en  (daz_en),
      .sel_val (sel_val),
      .smode   (sgn_mode_e'(ctl[3:2])),
      .res     (c_res),
      .inv     (c_inv),
      .den     (c_den)
   );

   assign c_ill = |ctl[CTL_W-1:4];

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_denorm  <= 1'b0;
            ctl_illegal  <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               result       <= c_res;
               flag_invalid <= c_inv;
               flag_denorm  <= c_den;
               ctl_illegal  <= c_ill;
            end
         end
      end

      a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(result)));
      a_r4_snan_quieted: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && cls[0].snan) |=> (flag_invalid && result[FRAC_W-1]));
      a_r5_qnan_pair: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && cls[0].qnan && cls[1].qnan) |=>
            (!flag_invalid && result[W-2:0] == $past(opnd_a[W-2:0])));
      a_r6_zero_pair: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && cls[0].zero && cls[1].zero && (opnd_a[W-1] != opnd_b[W-1]))
            |=> (result[W-2:0] == '0));
      a_r10_illegal: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && |ctl[CTL_W-1:4]) |=> ctl_illegal);
   end else begin : g_comb
      assign out_valid    = in_valid;
      assign result       = c_res;
      assign flag_invalid = c_inv;
      assign flag_denorm  = c_den;
      assign ctl_illegal  = c_ill;
   end

   a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      flag_invalid |-> !flag_denorm);
endmodule

// File: tb/sim_dp_range_sel.sv
module sim_dp_range_sel;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] QB = 64'h0008_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] opnd_a = '0, opnd_b = '0;
   logic [7:0]  ctl = '0;
   logic        daz_en = 1'b0;
   logic        out_valid, flag_invalid, flag_denorm, ctl_illegal;
   logic [63:0] result;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dp_range_sel u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .ctl(ctl), .daz_en(daz_en), .out_valid(out_valid), .result(result),
      .flag_invalid(flag_invalid), .flag_denorm(flag_denorm), .ctl_illegal(ctl_illegal)
   );

   function automatic bit is_snan(input logic [63:0] x);
      return (x[62:52] == 11'h7ff) && !x[51] && (x[50:0] != 0);
   endfunction
   function automatic bit is_qnan(input logic [63:0] x);
      return (x[62:52] == 11'h7ff) && x[51];
   endfunction
   function automatic bit is_dn(input logic [63:0] x);
      return (x[62:52] == 0) && (x[51:0] != 0);
   endfunction
   function automatic logic [63:0] okey(input logic [63:0] x);
      return x[63] ? ~x : {1'b1, x[62:0]};
   endfunction

   // expected {result, invalid, denorm, illegal}
   function automatic logic [66:0] model(input logic [63:0] a, b, input logic [7:0] c, input logic daz);
      logic [63:0] fa, fb, tmp;
      logic ill, den, le, sg;
      ill = |c[7:4];
      if (is_snan(a)) return {a | QB, 1'b1, 1'b0, ill};
      if (is_snan(b)) return {b | QB, 1'b1, 1'b0, ill};
      fa = (daz && is_dn(a)) ? {a[63], 63'b0} : a;
      fb = (daz && is_dn(b)) ? {b[63], 63'b0} : b;
      den = !daz && ((is_dn(a) && !is_qnan(b)) || (is_dn(b) && !is_qnan(a)));
      if (is_qnan(b)) tmp = fa;
      else if (is_qnan(a)) tmp = fb;
      else if (fa[62:0] == 0 && fb[62:0] == 0 && fa[63] != fb[63])
         tmp = c[0] ? 64'h0 : 64'h8000_0000_0000_0000;
      else if (c[1] && fa[62:0] == fb[62:0] && fa[63] != fb[63])
         tmp = (c[0] ^ fa[63]) ? fa : fb;
      else begin
         le = c[1] ? (fa[62:0] <= fb[62:0]) : (okey(fa) <= okey(fb));
         tmp = (le ^ c[0]) ? fa : fb;
      end
      case (c[3:2])
         2'b00: sg = a[63];
         2'b01: sg = tmp[63];
         2'b10: sg = 1'b0;
         default: sg = 1'b1;
      endcase
      return {sg, tmp[62:0], 1'b0, den, ill};
   endfunction

   function automatic string tag_of(input logic [63:0] a, b, input logic [7:0] c, input logic daz);
      if (c[7:4] != 0) return "R10";
      if (is_snan(a) || is_snan(b)) return "R4";
      if (is_qnan(a) || is_qnan(b)) return "R5";
      if (daz && (is_dn(a) || is_dn(b))) return "R9";
      if (is_dn(a) || is_dn(b)) return "R8";
      if (a[62:0] == 0 && b[62:0] == 0 && a[63] != b[63]) return "R6";
      if (c[1] && a[62:0] == b[62:0] && a[63] != b[63]) return "R7";
      if (c[3:2] != 2'b01) return "R3";
      if (c[1]) return "R2";
      return "R1";
   endfunction

   task automatic check(input string req, input logic [66:0] act, exp_v);
      n_chk++;
      if (act !== exp_v) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp_v);
      end
   endtask

   // drive at a falling edge, compare at the next falling edge
   task automatic apply(input logic [63:0] a, b, input logic [7:0] c, input logic daz, input string req);
      opnd_a = a; opnd_b = b; ctl = c; daz_en = daz; in_valid = 1'b1;
      @(negedge clk);
      check(req, {result, flag_invalid, flag_denorm, ctl_illegal}, model(a, b, c, daz));
      check("R11", {66'b0, out_valid}, 67'd1);
   endtask

   function automatic logic [63:0] gen(input int kind, input logic [63:0] other);
      logic s;
      s = 1'($urandom);
      case (kind)
         0, 1: return {$urandom, $urandom};
         2: return {s, 63'b0};
         3: return {s, 11'h7ff, 52'b0};
         4: return {s, 11'h7ff, 1'b1, 19'($urandom), $urandom};
         5: return {s, 11'h7ff, 1'b0, 19'($urandom), $urandom | 32'd1};
         6: return {s, 11'h0, 20'($urandom), $urandom | 32'd1};
         7: return {~other[63], other[62:0]};
         default: return {s, other[62:0]};
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] a, b, prev;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11", {result, flag_invalid, flag_denorm, ctl_illegal, out_valid}[67:1], 67'd0);
      check("R11", {66'b0, out_valid}, 67'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      apply(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 8'h04, 0, "R1");
      apply(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 8'h05, 0, "R1");
      apply(64'hC008_0000_0000_0000, 64'h4000_0000_0000_0000, 8'h06, 0, "R2");
      apply(64'hC008_0000_0000_0000, 64'h4000_0000_0000_0000, 8'h07, 0, "R2");
      apply(64'hC0A0_0000_0000_0000, 64'h408F_F800_0000_0000, 8'h02, 0, "R3");
      apply(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 8'h0D, 0, "R3");
      apply(64'h7FF0_0000_0000_0001, 64'h7FF4_0000_0000_0000, 8'h0C, 0, "R4");
      apply(64'h3FF0_0000_0000_0000, 64'hFFF0_0000_0000_0002, 8'h08, 0, "R4");
      apply(64'h7FF8_0000_0000_0001, 64'hFFF8_0000_0000_0002, 8'h04, 0, "R5");
      apply(64'h7FF8_0000_0000_0000, 64'hBFF0_0000_0000_0000, 8'h08, 0, "R5");
      for (int m = 0; m < 4; m++) begin
         apply(64'h0, 64'h8000_0000_0000_0000, 8'(m) | 8'h04, 0, "R6");
         apply(64'h8000_0000_0000_0000, 64'h0, 8'(m) | 8'h04, 0, "R6");
      end
      apply(64'h4014_0000_0000_0000, 64'hC014_0000_0000_0000, 8'h06, 0, "R7");
      apply(64'hC014_0000_0000_0000, 64'h4014_0000_0000_0000, 8'h07, 0, "R7");
      apply(64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 8'h06, 0, "R7");
      apply(64'h0000_0000_0000_0005, 64'h3FF0_0000_0000_0000, 8'h04, 0, "R8");
      apply(64'h0000_0000_0000_0005, 64'h7FF8_0000_0000_0000, 8'h04, 0, "R8");
      apply(64'h0000_0000_0000_0005, 64'h8000_0000_0000_0000, 8'h04, 1, "R9");
      apply(64'h8000_0000_0000_0009, 64'h0000_0000_0000_0001, 8'h05, 1, "R9");
      apply(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 8'h35, 0, "R10");
      apply(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 8'h85, 0, "R10");

      // R11 hold while idle
      prev = result;
      in_valid = 1'b0; opnd_a = 64'h4010_0000_0000_0000; opnd_b = 64'hC010_0000_0000_0000;
      @(negedge clk);
      check("R11", {3'b0, result}, {3'b0, prev});
      check("R11", {66'b0, out_valid}, 67'd0);

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] c;
         a = gen(int'($urandom % 9), 64'h3FF8_0000_0000_0000);
         b = gen(int'($urandom % 9), a);
         c = {(($urandom % 8) == 0) ? 4'($urandom) : 4'h0, 4'($urandom)};
         if ($urandom % 2) begin
            logic [63:0] t;
            t = a; a = b; b = t;
         end
         apply(a, b, c, 1'($urandom % 4 == 0), tag_of(a, b, c, daz_en));
         if (i % 97 == 0) begin
            prev = result;
            in_valid = 1'b0; opnd_a = ~opnd_a;
            @(negedge clk);
            check("R11", {3'b0, result}, {3'b0, prev});
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule